// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 32-bit processor datapath and a data memory that is 32 bits wide and addressed by byte. For each request it adds a sign-extended 16-bit instruction offset to a base register value to form the effective address. It then checks that the access is naturally aligned for its size: byte, halfword or word.

An aligned store produces a word-aligned memory address, a 4-bit byte-enable vector and store data copied into the selected byte lanes. An aligned load issues a read strobe. In the next cycle the unit takes the addressed byte or halfword from the returned word, places it at the bottom of the result and extends it with sign or zeros. A misaligned request does not reach memory. It raises a one-cycle flag instead. Lanes follow big-endian order: the lowest byte address is the most-significant byte of the word.

A small state machine sequences each request. Its states are `ST_IDLE` (ready), `ST_ISSUE` (memory strobe cycle), `ST_RESP` (load data returned) and `ST_FAULT` (misalignment reported). Its transitions are:
- IDLE→ISSUE on an aligned request.
- IDLE→FAULT on a misaligned request.
- ISSUE→RESP for a load.
- ISSUE→IDLE for a store.
- RESP→IDLE.
- FAULT→IDLE.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `base_val` plus `offset_imm` sign-extended to 32 bits. While a strobe is high, `mem_addr` equals the effective address with bits 1:0 forced to 0.
- R2: Size codes on `req_size` are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. A byte is always aligned. A halfword needs address bit 0 = 0. A word needs address bits 1:0 = 00. Code 3 is always treated as misaligned.
- R3: A request accepted in ST_IDLE that breaks alignment drives `misalign` high for exactly the next cycle. During that cycle `mem_rd`, `mem_wr` and `load_valid` stay low.
- R4: An aligned store drives `mem_wr` high for exactly the cycle after acceptance. `mem_be[3]` covers data bits 31:24 (address offset 0) and `mem_be[0]` covers bits 7:0 (offset 3). The pattern is:
  - Byte: only the bit for the offset (1000, 0100, 0010, 0001).
  - Halfword at offset 0: 1100. Halfword at offset 2: 0011.
  - Word: 1111.
- R5: Store data on `mem_wdata` is replicated by size:
  - Byte: `store_data[7:0]` in all four lanes.
  - Halfword: `store_data[15:0]` in both halves.
  - Word: `store_data` unchanged.
- R6: An aligned load drives `mem_rd` high, with the R4 byte enables, for exactly the cycle after acceptance. In the following cycle it samples `mem_rdata` and pulses `load_valid` with `load_data`.
- R7: A byte load at offset k returns `mem_rdata[31-8k:24-8k]` in bits 7:0.
- R8: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2, in bits 15:0.
- R9: When `req_signed` = 1, byte and halfword loads are sign-extended. When it is 0, they are zero-extended. A word load ignores `req_signed`.
- R10: `busy` is high outside ST_IDLE. A request presented while `busy` is high is ignored: it starts no strobe and does not change the access in progress.
- R11: After reset, `busy`, `mem_rd`, `mem_wr`, `misalign` and `load_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend load result |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Instruction offset |
| store_data | input | 32 | Register value to store |
| busy | output | 1 | Request in progress |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned by memory |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned request flag |

## Verification
The four states are visible at the ports, so a wrong state shows up within one or two cycles of acceptance:
- A stray transition to ST_FAULT shows as a `misalign` pulse together with a missing strobe.
- Skipping ST_RESP loses the `load_valid` pulse.
- Staying in a state too long stretches a strobe or leaves `busy` high one cycle late.

Wrongly latched lane or size fields show in the same cycle as the strobe, as a wrong `mem_be` or `mem_wdata`. They also show one cycle later, as a wrongly selected or wrongly extended `load_data`.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2,
        ST_FAULT = 2'd3
    } lsu_state_t;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int LANE_BITS = 2
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  acc_size_t            size,
    output logic [ADDR_W-1:0]    eff_addr,
    output logic [LANE_BITS-1:0] lane,
    output logic                 aligned
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign eff_addr = base + off_ext;
    assign lane     = eff_addr[LANE_BITS-1:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = ~eff_addr[0];
            SZ_WORD: aligned = (eff_addr[LANE_BITS-1:0] == '0);
            default: aligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  lane,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W/8-1:0]          be,
    output logic [DATA_W-1:0]            lane_data
);

    localparam int BYTES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(BYTES);

    // Address offset i drives big-endian lane bits [DATA_W-1-8i -: 8].
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - 8 * i;
        logic       hit;
        logic [7:0] byte_val;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    hit      = (lane == LANE_BITS'(i));
                    byte_val = wdata[7:0];
                end
                SZ_HALF: begin
                    hit      = (lane[LANE_BITS-1:1] == (LANE_BITS-1)'(i / 2));
                    byte_val = (i % 2 == 0) ? wdata[15:8] : wdata[7:0];
                end
                SZ_WORD: begin
                    hit      = 1'b1;
                    byte_val = wdata[HI -: 8];
                end
                default: begin
                    hit      = 1'b0;
                    byte_val = 8'h00;
                end
            endcase
        end

        assign be[BYTES-1-i]   = hit;
        assign lane_data[HI -: 8] = byte_val;
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  lane,
    input  logic                         sgn,
    input  logic [DATA_W-1:0]            rdata,
    output logic [DATA_W-1:0]            result
);

    localparam int BYTES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(BYTES);

    logic [7:0]  byte_pick;
    logic [15:0] half_pick;
    int          bidx;
    int          hidx;

    always_comb begin
        bidx      = int'(lane);
        hidx      = int'(lane[LANE_BITS-1:1]);
        byte_pick = rdata[(DATA_W - 1) - 8 * bidx -: 8];
        half_pick = rdata[(DATA_W - 1) - 16 * hidx -: 16];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sgn & byte_pick[7]}}, byte_pick};
            SZ_HALF: result = {{(DATA_W-16){sgn & half_pick[15]}}, half_pick};
            SZ_WORD: result = rdata;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset_imm,
    input  logic [DATA_W-1:0] store_data,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data,
    output logic              misalign
);

    localparam int BYTES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(BYTES);

    lsu_state_t state_q, state_d;

    acc_size_t             req_sz;
    logic [ADDR_W-1:0]     ea;
    logic [LANE_BITS-1:0]  ea_lane;
    logic                  ea_ok;
    logic [BYTES-1:0]      be_c;
    logic [DATA_W-1:0]     wd_c;
    logic [DATA_W-1:0]     ext_c;
    logic                  accept;

    logic [ADDR_W-1:0]     addr_q;
    logic [BYTES-1:0]      be_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  store_q;
    logic                  sgn_q;
    acc_size_t             size_q;
    logic [LANE_BITS-1:0]  lane_q;

    assign req_sz = acc_size_t'(req_size);
    assign accept = req_valid && (state_q == ST_IDLE);

    lsu_addr_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .LANE_BITS (LANE_BITS)
    ) u_agen (
        .base     (base_val),
        .offset   (offset_imm),
        .size     (req_sz),
        .eff_addr (ea),
        .lane     (ea_lane),
        .aligned  (ea_ok)
    );

    lsu_store_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .size      (req_sz),
        .lane      (ea_lane),
        .wdata     (store_data),
        .be        (be_c),
        .lane_data (wd_c)
    );

    lsu_load_extract #(
        .DATA_W (DATA_W)
    ) u_extract (
        .size   (size_q),
        .lane   (lane_q),
        .sgn    (sgn_q),
        .rdata  (mem_rdata),
        .result (ext_c)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ea_ok ? ST_ISSUE : ST_FAULT;
            ST_ISSUE: state_d = store_q ? ST_IDLE : ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            store_q <= 1'b0;
            sgn_q   <= 1'b0;
            size_q  <= SZ_BYTE;
            lane_q  <= '0;
        end else if (accept) begin
            addr_q  <= {ea[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
            be_q    <= be_c;
            wdata_q <= wd_c;
            store_q <= req_store;
            sgn_q   <= req_signed;
            size_q  <= req_sz;
            lane_q  <= ea_lane;
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy       = 1'b1;
        mem_addr   = addr_q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_be     = '0;
        mem_wdata  = '0;
        load_valid = 1'b0;
        load_data  = '0;
        misalign   = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ISSUE: begin
                mem_rd    = ~store_q;
                mem_wr    = store_q;
                mem_be    = be_q;
                mem_wdata = store_q ? wdata_q : '0;
            end
            ST_RESP: begin
                load_valid = 1'b1;
                load_data  = ext_c;
            end
            ST_FAULT: misalign = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R3
    misalign_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_rd && !mem_wr && !load_valid));

    // R3
    misalign_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !misalign);

    // R1
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[LANE_BITS-1:0] == '0));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    rd_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (load_valid && !mem_rd));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mem_addr));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

endmodule

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] base_val = '0;
    logic [15:0] offset_imm = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic        busy, mem_rd, mem_wr, load_valid, misalign;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsu_align_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .base_val(base_val),
        .offset_imm(offset_imm), .store_data(store_data), .busy(busy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
        .load_data(load_data), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] ln);
        case (sz)
            2'd0: return 4'b1000 >> ln;
            2'd1: return ln[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0: return {4{d[7:0]}};
            2'd1: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] ln,
                                           input logic sg, input logic [31:0] rd);
        logic [7:0]  b;
        logic [15:0] h;
        b = rd[31 - 8*ln -: 8];
        h = ln[1] ? rd[15:0] : rd[31:16];
        case (sz)
            2'd0: return sg ? {{24{b[7]}}, b} : {24'h0, b};
            2'd1: return sg ? {{16{h[15]}}, h} : {16'h0, h};
            default: return rd;
        endcase
    endfunction

    task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                         input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        base_val = b; offset_imm = o; store_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R1 R4 R5: aligned store
    task automatic do_store(input logic [1:0] sz, input logic [31:0] b,
                            input logic [15:0] o, input logic [31:0] d);
        logic [31:0] ea;
        ea = ea_of(b, o);
        drive(1'b1, sz, 1'b0, b, o, d);
        chk("R4 mem_wr", {31'h0, mem_wr}, 32'h1);
        chk("R4 mem_rd low", {31'h0, mem_rd}, 32'h0);
        chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
        chk("R4 mem_be", {28'h0, mem_be}, {28'h0, exp_be(sz, ea[1:0])});
        chk("R5 mem_wdata", mem_wdata, exp_wd(sz, d));
        chk("R10 busy", {31'h0, busy}, 32'h1);
        @(negedge clk);
        chk("R4 wr one cycle", {31'h0, mem_wr}, 32'h0);
        chk("R10 idle again", {31'h0, busy}, 32'h0);
    endtask

    // R6 R7 R8 R9: aligned load
    task automatic do_load(input logic [1:0] sz, input logic sg, input logic [31:0] b,
                           input logic [15:0] o, input logic [31:0] rd);
        logic [31:0] ea;
        ea = ea_of(b, o);
        mem_rdata = rd;
        drive(1'b0, sz, sg, b, o, 32'hDEAD_BEEF);
        chk("R6 mem_rd", {31'h0, mem_rd}, 32'h1);
        chk("R6 mem_wr low", {31'h0, mem_wr}, 32'h0);
        chk("R1 load addr", mem_addr, {ea[31:2], 2'b00});
        chk("R6 load be", {28'h0, mem_be}, {28'h0, exp_be(sz, ea[1:0])});
        @(negedge clk);
        chk("R6 load_valid", {31'h0, load_valid}, 32'h1);
        chk("R7 R8 R9 load_data", load_data, exp_ld(sz, ea[1:0], sg, rd));
        @(negedge clk);
        chk("R6 valid one cycle", {31'h0, load_valid}, 32'h0);
    endtask

    // R2 R3: misaligned request
    task automatic do_misaligned(input logic st, input logic [1:0] sz,
                                 input logic [31:0] b, input logic [15:0] o);
        drive(st, sz, 1'b0, b, o, 32'h1234_5678);
        chk("R3 misalign high", {31'h0, misalign}, 32'h1);
        chk("R3 no strobe", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R3 no load_valid", {31'h0, load_valid}, 32'h0);
        @(negedge clk);
        chk("R3 misalign one cycle", {31'h0, misalign}, 32'h0);
        chk("R3 no late strobe", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R3 idle", {31'h0, busy}, 32'h0);
    endtask

    // R10: request while busy ignored
    task automatic do_busy_ignore();
        mem_rdata = 32'hA1B2_C3D4;
        drive(1'b0, 2'd2, 1'b0, 32'h0000_1000, 16'h0004, 32'h0);
        req_valid = 1'b1; req_store = 1'b1; req_size = 2'd0;
        base_val = 32'h0000_2000; offset_imm = 16'h0001; store_data = 32'hFF;
        chk("R10 addr kept", mem_addr, 32'h0000_1004);
        chk("R10 first rd", {31'h0, mem_rd}, 32'h1);
        @(negedge clk);
        chk("R10 load finishes", load_data, 32'hA1B2_C3D4);
        chk("R10 no wr", {31'h0, mem_wr}, 32'h0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 no extra wr", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R10 busy low", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #5;
        // R11
        chk("R11 busy", {31'h0, busy}, 32'h0);
        chk("R11 strobes", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R11 flags", {30'h0, misalign, load_valid}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++)
            do_store(2'd0, 32'h0000_0100, 16'(k), 32'h0000_00A5 + k);
        do_store(2'd1, 32'h0000_0200, 16'h0000, 32'h0000_BEEF);
        do_store(2'd1, 32'h0000_0200, 16'h0002, 32'h0000_1357);
        do_store(2'd2, 32'h0000_0300, 16'h0008, 32'h1122_3344);
        // R1: negative offset
        do_store(2'd2, 32'h0000_0400, 16'hFFFC, 32'hCAFE_F00D);
        do_store(2'd0, 32'h0000_0010, 16'hFFF3, 32'h0000_0077);

        for (int k = 0; k < 4; k++) begin
            do_load(2'd0, 1'b1, 32'h0000_0500, 16'(k), 32'h80F1_7F22);
            do_load(2'd0, 1'b0, 32'h0000_0500, 16'(k), 32'h80F1_7F22);
        end
        do_load(2'd1, 1'b1, 32'h0000_0600, 16'h0000, 32'h80F1_7F22);
        do_load(2'd1, 1'b0, 32'h0000_0600, 16'h0000, 32'h80F1_7F22);
        do_load(2'd1, 1'b1, 32'h0000_0600, 16'h0002, 32'h80F1_FF22);
        do_load(2'd1, 1'b0, 32'h0000_0600, 16'h0002, 32'h80F1_FF22);
        do_load(2'd2, 1'b1, 32'h0000_0700, 16'h0000, 32'h80F1_7F22);
        do_load(2'd2, 1'b0, 32'h0000_0700, 16'hFFF8, 32'h0123_4567);

        // R2: halfword odd, word offsets 1..3, reserved size
        do_misaligned(1'b1, 2'd1, 32'h0000_0800, 16'h0001);
        do_misaligned(1'b0, 2'd1, 32'h0000_0802, 16'h0001);
        do_misaligned(1'b1, 2'd2, 32'h0000_0800, 16'h0002);
        do_misaligned(1'b0, 2'd2, 32'h0000_0801, 16'h0000);
        do_misaligned(1'b0, 2'd2, 32'h0000_0800, 16'hFFFF);
        do_misaligned(1'b1, 2'd3, 32'h0000_0800, 16'h0000);

        do_busy_ignore();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule